// File: doc/BRIEF.md
# Multi-Master System Bus Arbiter

This block decides, for one processor, when that processor may drive a system bus that several bus masters share. It watches the processor's three status lines: any code other than the passive code means a bus cycle is starting and the bus is needed, and the passive code marks the end of a cycle. It asks for the bus on an active-low request line and takes part in a serial priority chain with a priority input and a priority output. A shared, open-collector-style busy line tells it whether another master still holds the bus. Once it has the bus, it drives busy itself and enables the local bus controller's address outputs through an active-low address-enable.

After a transfer the arbiter keeps the bus ("parks") until something makes it give the bus up. Either a higher-priority master appears on the priority input, or a lower-priority master pulls the shared common-request line while the any-request strap is set, or the processor moves to a resident bus. Two active-low lock inputs can block these surrenders. The processor lock blocks every surrender. The common-request lock blocks only a surrender caused by the common-request line. Surrender happens only on a clock edge where the status lines show the passive code, so a bus cycle in progress is never cut short.

All inputs are sampled on one clock. The processor clock and the system bus clock are treated as the same synchronous clock.

Top module: `mm_bus_arbiter`

## Requirements
- R1: While the synchronous active-low `init_n` is low at a clock edge, the arbiter goes idle after that edge: `breq_n`, `busy_n_out`, `aen_n` and `cbrq_n_out` all read 1.
- R2: In idle, an edge that samples a status code other than the passive code 3'b111 (and that R11 allows) drives `breq_n` low after that edge, without yet asserting `aen_n`.
- R3: While requesting, the bus is taken at the first edge that samples `prio_in_n`=0 and `busy_n_in`=1. `busy_n_out` and `aen_n` then go low and `breq_n` stays low. While `busy_n_in`=0 the arbiter keeps waiting.
- R4: `prio_out_n` is 0 exactly when `prio_in_n` is 0 and the arbiter is idle (not requesting and not owning). The output follows the input in the same cycle.
- R5: `cbrq_n_out` is 0 exactly while the arbiter is requesting, does not yet own the bus, and sees `prio_in_n`=1.
- R6: An owned bus is released only at an edge where the status lines show 3'b111. With no surrender cause, the bus stays owned across idle status (parking).
- R7: Owning with `prio_in_n`=1 causes surrender at the first edge with passive status.
- R8: With `anyreq_strap`=1 and `cbrq_n_in`=0, the bus is surrendered at the first passive-status edge (after every transfer if held low). With `anyreq_strap`=0, `cbrq_n_in` has no effect.
- R9: `crq_lock_n`=0 blocks the R8 surrender cause but not the R7 cause.
- R10: `lock_n`=0 blocks every surrender; the bus is kept while it stays low.
- R11: With `res_strap`=1, status activity requests the bus only while `sys_sel`=1, and an owned bus is surrendered at a passive-status edge while `sys_sel`=0. With `res_strap`=0, `sys_sel` is ignored.
- R12: On surrender, `breq_n`, `busy_n_out` and `aen_n` all return to 1 after the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every arbiter action |
| init_n | input | 1 | Synchronous active-low init |
| stat | input | 3 | Processor status lines, 3'b111 = passive |
| lock_n | input | 1 | Processor lock, active low, blocks all surrender |
| crq_lock_n | input | 1 | Common-request lock, active low |
| res_strap | input | 1 | Resident-bus strap |
| sys_sel | input | 1 | 1 = cycle targets the system bus (used when res_strap=1) |
| anyreq_strap | input | 1 | Any-request strap |
| prio_in_n | input | 1 | Priority from the chain, active low |
| prio_out_n | output | 1 | Priority passed down the chain, active low |
| busy_n_in | input | 1 | Shared busy line as seen on the bus |
| busy_n_out | output | 1 | Busy drive, low while owning |
| cbrq_n_in | input | 1 | Shared common-request line as seen on the bus |
| cbrq_n_out | output | 1 | Common-request drive, active low |
| breq_n | output | 1 | Bus request, active low |
| aen_n | output | 1 | Address enable to the local bus controller, active low |

## Verification
The bench goes after surrender timing. It removes priority and pulls common-request in the middle of a bus cycle. A design that tested for the cause without also checking the passive status would drop the bus mid-transfer. It also holds each lock input against each surrender cause. An arbiter whose common-request lock also blocked a priority loss would hold the bus against a higher-priority master forever. A design that applied the lock only to one cause would give the bus away while the processor holds it locked. It keeps the busy line low while priority is granted, because an arbiter that ignored busy would drive the bus at the same time as another master. Finally, it flips `sys_sel` with the resident strap both set and clear, which catches a decoder that ignores the strap or honours the select when it should not.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_REQ  = 2'd1,
    ARB_OWN  = 2'd2
  } arb_state_e;

  localparam int unsigned STAT_W_DEF = 3;
endpackage

// File: rtl/arb_status_decode.sv
module arb_status_decode #(
  parameter int unsigned          STAT_W  = 3,
  parameter logic [STAT_W-1:0]    PASSIVE = '1
) (
  input  logic [STAT_W-1:0] stat,
  input  logic              res_strap,
  input  logic              sys_sel,
  output logic              need_bus,
  output logic              cycle_done,
  output logic              left_sysbus
);
  logic target_sys;

  always_comb begin
    target_sys  = !res_strap || sys_sel;
    cycle_done  = (stat == PASSIVE);
    need_bus    = !cycle_done && target_sys;
    left_sysbus = res_strap && !sys_sel;
  end
endmodule

// File: rtl/arb_release_policy.sv
module arb_release_policy (
  input  logic cycle_done,
  input  logic lock_n,
  input  logic crq_lock_n,
  input  logic anyreq_strap,
  input  logic cbrq_n_in,
  input  logic prio_in_n,
  input  logic left_sysbus,
  output logic give_up
);
  logic lost_prio;
  logic common_req;
  logic any_cause;

  always_comb begin
    lost_prio  = prio_in_n;
    common_req = anyreq_strap && !cbrq_n_in && crq_lock_n;
    any_cause  = lost_prio || common_req || left_sysbus;
    give_up    = cycle_done && lock_n && any_cause;
  end
endmodule

// File: rtl/arb_ctrl_fsm.sv
module arb_ctrl_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic init_n,
  input  logic need_bus,
  input  logic cycle_done,
  input  logic give_up,
  input  logic prio_in_n,
  input  logic busy_n_in,
  input  logic lock_n,
  output arb_state_e state
);
  arb_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ARB_IDLE: if (need_bus) state_nx = ARB_REQ;
      ARB_REQ:  if (!prio_in_n && busy_n_in) state_nx = ARB_OWN;
      ARB_OWN:  if (give_up) state_nx = ARB_IDLE;
      default:  state_nx = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!init_n) state <= ARB_IDLE;
    else         state <= state_nx;
  end

  // R3: the bus is taken only with priority held and busy released
  a_r3_grant_needs_free_bus: assert property (@(posedge clk) disable iff (!init_n)
    (state == ARB_REQ && !(!prio_in_n && busy_n_in)) |=> state != ARB_OWN);

  // R10: processor lock keeps the bus
  a_r10_lock_holds_bus: assert property (@(posedge clk) disable iff (!init_n)
    (state == ARB_OWN && !lock_n) |=> state == ARB_OWN);

  // R6: no release while a bus cycle is running
  a_r6_no_midcycle_release: assert property (@(posedge clk) disable iff (!init_n)
    (state == ARB_OWN && !cycle_done) |=> state == ARB_OWN);

  // R2: ownership always passes through a request
  a_r2_request_first: assert property (@(posedge clk) disable iff (!init_n)
    (state == ARB_IDLE) |=> state != ARB_OWN);
endmodule

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned       STAT_W  = STAT_W_DEF,
  parameter logic [STAT_W-1:0] PASSIVE = '1
) (
  input  logic              clk,
  input  logic              init_n,
  input  logic [STAT_W-1:0] stat,
  input  logic              lock_n,
  input  logic              crq_lock_n,
  input  logic              res_strap,
  input  logic              sys_sel,
  input  logic              anyreq_strap,
  input  logic              prio_in_n,
  output logic              prio_out_n,
  input  logic              busy_n_in,
  output logic              busy_n_out,
  input  logic              cbrq_n_in,
  output logic              cbrq_n_out,
  output logic              breq_n,
  output logic              aen_n
);
  logic       need_bus;
  logic       cycle_done;
  logic       left_sysbus;
  logic       give_up;
  arb_state_e state;

  arb_status_decode #(.STAT_W(STAT_W), .PASSIVE(PASSIVE)) u_dec (
    .stat        (stat),
    .res_strap   (res_strap),
    .sys_sel     (sys_sel),
    .need_bus    (need_bus),
    .cycle_done  (cycle_done),
    .left_sysbus (left_sysbus)
  );

  arb_release_policy u_pol (
    .cycle_done   (cycle_done),
    .lock_n       (lock_n),
    .crq_lock_n   (crq_lock_n),
    .anyreq_strap (anyreq_strap),
    .cbrq_n_in    (cbrq_n_in),
    .prio_in_n    (prio_in_n),
    .left_sysbus  (left_sysbus),
    .give_up      (give_up)
  );

  arb_ctrl_fsm u_fsm (
    .clk        (clk),
    .init_n     (init_n),
    .need_bus   (need_bus),
    .cycle_done (cycle_done),
    .give_up    (give_up),
    .prio_in_n  (prio_in_n),
    .busy_n_in  (busy_n_in),
    .lock_n     (lock_n),
    .state      (state)
  );

  always_comb begin
    breq_n     = (state == ARB_IDLE);
    busy_n_out = (state != ARB_OWN);
    aen_n      = (state != ARB_OWN);
    prio_out_n = !(state == ARB_IDLE && !prio_in_n);
    cbrq_n_out = !(state == ARB_REQ && prio_in_n);
  end

  // R11: a resident-bus cycle never raises a request from idle
  a_r11_resident_no_request: assert property (@(posedge clk) disable iff (!init_n)
    (breq_n && res_strap && !sys_sel) |=> breq_n);

  // R12: release of the bus drops request and busy together
  a_r12_release_together: assert property (@(posedge clk) disable iff (!init_n)
    $rose(aen_n) |-> (breq_n && busy_n_out));
endmodule

// File: tb/mm_bus_arbiter_tb.sv
module mm_bus_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       init_n, lock_n, crq_lock_n, res_strap, sys_sel, anyreq_strap;
  logic       prio_in_n, busy_n_in, cbrq_n_in;
  logic [2:0] stat;
  logic       prio_out_n, busy_n_out, cbrq_n_out, breq_n, aen_n;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int m_st     = 0;   // 0 idle, 1 requesting, 2 owning
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_bus_arbiter u_dut (
    .clk(clk), .init_n(init_n), .stat(stat), .lock_n(lock_n),
    .crq_lock_n(crq_lock_n), .res_strap(res_strap), .sys_sel(sys_sel),
    .anyreq_strap(anyreq_strap), .prio_in_n(prio_in_n), .prio_out_n(prio_out_n),
    .busy_n_in(busy_n_in), .busy_n_out(busy_n_out), .cbrq_n_in(cbrq_n_in),
    .cbrq_n_out(cbrq_n_out), .breq_n(breq_n), .aen_n(aen_n)
  );

  // behavioural reference
  always @(posedge clk) begin
    bit passive, wants, drop;
    cycles  = cycles + 1;
    passive = (stat == 3'b111);
    wants   = !passive && (!res_strap || sys_sel);
    drop    = passive && lock_n &&
              (prio_in_n || (anyreq_strap && !cbrq_n_in && crq_lock_n) ||
               (res_strap && !sys_sel));
    if (!init_n) m_st = 0;
    else if (m_st == 0 && wants) m_st = 1;
    else if (m_st == 1 && !prio_in_n && busy_n_in) m_st = 2;
    else if (m_st == 2 && drop) m_st = 0;
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // every-cycle comparison with the reference
  always @(negedge clk) begin
    #1;
    if (cycles > 2) begin
      chk(breq_n,     !(m_st != 0),                   "R2 breq_n vs model");
      chk(busy_n_out, !(m_st == 2),                   "R3 busy_n_out vs model");
      chk(aen_n,      !(m_st == 2),                   "R12 aen_n vs model");
      chk(prio_out_n, !(m_st == 0 && !prio_in_n),     "R4 prio_out_n vs model");
      chk(cbrq_n_out, !(m_st == 1 && prio_in_n),      "R5 cbrq_n_out vs model");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > WATCHDOG);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
    finish_run();
  end

  initial begin
    init_n = 0; stat = 3'b111; lock_n = 1; crq_lock_n = 1; res_strap = 0;
    sys_sel = 0; anyreq_strap = 0; prio_in_n = 0; busy_n_in = 1; cbrq_n_in = 1;
    tick(3);
    // R1 reset state
    chk(breq_n, 1, "R1 breq_n"); chk(aen_n, 1, "R1 aen_n");
    chk(busy_n_out, 1, "R1 busy_n_out"); chk(cbrq_n_out, 1, "R1 cbrq_n_out");
    init_n = 1; tick(2);
    chk(prio_out_n, 0, "R4 idle passes priority");
    // R2 / R3 request then acquire
    stat = 3'b100; tick(1);
    chk(breq_n, 0, "R2 request raised"); chk(aen_n, 1, "R2 not yet owned");
    tick(1);
    chk(aen_n, 0, "R3 acquired"); chk(breq_n, 0, "R3 request held while owning");
    // R6 parking
    stat = 3'b111; tick(3);
    chk(aen_n, 0, "R6 parked bus kept");
    // R7 priority loss mid-cycle
    stat = 3'b001; prio_in_n = 1; tick(2);
    chk(aen_n, 0, "R6 no release mid-cycle");
    stat = 3'b111; tick(1);
    chk(aen_n, 1, "R7 released at passive"); chk(breq_n, 1, "R12 breq_n on release");
    chk(busy_n_out, 1, "R12 busy_n_out on release");
    // R5 common request without priority; R3 busy wait
    stat = 3'b010; tick(1);
    chk(cbrq_n_out, 0, "R5 common request raised");
    busy_n_in = 0; prio_in_n = 0; tick(2);
    chk(aen_n, 1, "R3 waits for busy");
    chk(cbrq_n_out, 1, "R5 released with priority");
    busy_n_in = 1; tick(1);
    chk(aen_n, 0, "R3 acquired after busy");
    stat = 3'b111;
    // R10 processor lock
    lock_n = 0; prio_in_n = 1; tick(3);
    chk(aen_n, 0, "R10 lock keeps bus");
    lock_n = 1; tick(1);
    chk(aen_n, 1, "R10 released after unlock");
    prio_in_n = 0;
    // R8 any-request surrender
    stat = 3'b100; tick(2);
    anyreq_strap = 1; cbrq_n_in = 0; tick(2);
    chk(aen_n, 0, "R8 held during cycle");
    stat = 3'b111; tick(1);
    chk(aen_n, 1, "R8 surrender at end of cycle");
    // R9 common-request lock
    crq_lock_n = 0; stat = 3'b100; tick(2); stat = 3'b111; tick(3);
    chk(aen_n, 0, "R9 crq lock keeps bus");
    prio_in_n = 1; tick(1);
    chk(aen_n, 1, "R9 priority loss still releases");
    prio_in_n = 0; crq_lock_n = 1;
    // R8 strap low ignores common request
    anyreq_strap = 0; stat = 3'b100; tick(2); stat = 3'b111; tick(3);
    chk(aen_n, 0, "R8 strap low ignores cbrq");
    cbrq_n_in = 1;
    // R11 resident bus strap
    res_strap = 1; sys_sel = 0; tick(1);
    chk(aen_n, 1, "R11 release on resident select");
    stat = 3'b100; tick(3);
    chk(breq_n, 1, "R11 resident cycle makes no request");
    sys_sel = 1; tick(2);
    chk(aen_n, 0, "R11 system select requests");
    res_strap = 0; sys_sel = 0; stat = 3'b111; tick(2);
    chk(aen_n, 0, "R11 select ignored with strap low");
    // R1 init while owning
    init_n = 0; tick(1);
    chk(aen_n, 1, "R1 init drops bus"); chk(breq_n, 1, "R1 init drops request");
    init_n = 1; tick(2);
    finish_run();
  end
endmodule